// File: doc/BRIEF.md
# Real-Time Clock Countdown Timer

This block is the countdown timer of a real-time clock. It holds an 8-bit counter that steps down once per selected tick while enabled. A two-bit source field picks the tick rate from four choices. Three of them arrive as single-cycle tick-enable strobes from a shared prescaler, at 4096 Hz, 64 Hz and 1 Hz. The fourth, 1/60 Hz, is built inside the block by a modulo-60 divider that counts 1 Hz strobes.

When the counter is at 1 and a selected tick arrives, it reloads from the reload register and raises a sticky flag. A reload value of n therefore gives a period of n ticks of the selected source. The flag stays set until software clears it. It drives a level interrupt through an interrupt-enable bit.

Software reaches the block through write strobes: one for the source field, one for the reload value, one for the enable and interrupt-enable pair, and one for the flag. The current count is visible on an output. After reset the source field is 1/60 Hz, the lowest-power choice for an idle timer.

Top module: `rtc_cdtimer`

## Requirements
- R1: After reset, count_o is 0, flag_o is 0, irq_o is 0, the timer is disabled, and the source field holds 2'b11 (1/60 Hz).
- R2: Source field encoding: 2'b00 selects tick_4k_i, 2'b01 selects tick_64_i, 2'b10 selects tick_1_i, and 2'b11 selects every 60th tick_1_i. The divide-by-60 counter returns to 0 on any write of the source field, so the next 1/60 Hz tick comes on the 60th 1 Hz tick after that write.
- R3: While enabled, count_o drops by one on each selected tick when it is above 1. It holds its value when the timer is disabled or when no selected tick arrives.
- R4: A selected tick while the timer is enabled and count_o is 1 loads count_o from the reload register and sets flag_o in the next cycle. A reload value of n therefore gives a period of n selected ticks.
- R5: A control write that sets the enable while the timer is disabled loads count_o from the reload register.
- R6: A reload write while the timer is enabled also loads count_o with the written value in the next cycle. While the timer is disabled, a reload write changes only the reload register and leaves count_o unchanged.
- R7: flag_o is sticky. A flag write with data 0 clears it, and a flag write with data 1 leaves it unchanged. A timer event in the same cycle as a clear leaves the flag set.
- R8: irq_o equals flag_o ANDed with the interrupt-enable bit.
- R9: When the reload register holds 0, count_o does not decrement and flag_o is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_4k_i | input | 1 | 4096 Hz single-cycle tick strobe |
| tick_64_i | input | 1 | 64 Hz single-cycle tick strobe |
| tick_1_i | input | 1 | 1 Hz single-cycle tick strobe |
| src_we_i | input | 1 | Source field write strobe |
| src_wdata_i | input | 2 | Source field write data |
| reload_we_i | input | 1 | Reload register write strobe |
| reload_wdata_i | input | 8 | Reload value write data |
| ctrl_we_i | input | 1 | Enable and interrupt-enable write strobe |
| en_wdata_i | input | 1 | Timer enable write data |
| ie_wdata_i | input | 1 | Interrupt enable write data |
| flag_we_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write data (0 clears) |
| flag_o | output | 1 | Sticky timer flag |
| irq_o | output | 1 | Level interrupt |
| count_o | output | 8 | Current counter value |

## Verification
The assertions check the following on every cycle:
- flag stickiness;
- that the interrupt never rises without the flag;
- the one-step decrement and the hold while no tick arrives;
- the wrap at 1;
- the loading on a reload write while enabled;
- the range of the divide-by-60 counter;
- the silence of the flag when the reload register is 0.

The reset source choice and the exact placement of the 1/60 Hz tick after a source write can only be shown by the bench scenarios. The same holds for the interplay of clear and set in one cycle and for disabled reload writes. The bench's cycle-accurate model compares count, flag and interrupt against the design on every cycle across all four sources.

// File: rtl/rtc_cdtimer_pkg.sv
package rtc_cdtimer_pkg;
  typedef enum logic [1:0] {
    SRC_4K  = 2'b00,
    SRC_64  = 2'b01,
    SRC_1   = 2'b10,
    SRC_MIN = 2'b11
  } tsrc_e;
endpackage

// File: rtl/rtc_min_div.sv
module rtc_min_div #(
  parameter int DIV = 60,
  localparam int W  = $clog2(DIV)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic         tick_o,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = tick_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/rtc_tick_mux.sv
module rtc_tick_mux
  import rtc_cdtimer_pkg::*;
#(
  parameter int NSRC = 4,
  localparam int SW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] ticks_i,
  input  logic [SW-1:0]   sel_i,
  output logic            tick_o
);
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = ticks_i[g] && (sel_i == SW'(g));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/rtc_cd_core.sv
module rtc_cd_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             wr_load_i,
  input  logic [CNT_W-1:0] wr_val_i,
  input  logic             en_load_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, fire;
  logic             live;

  // Timer runs only with a nonzero reload and a nonzero count.
  assign live = en_i && tick_i && (reload_i != '0) && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    fire  = 1'b0;
    if (wr_load_i && en_i) begin
      cnt_d = wr_val_i;
    end else if (en_load_i) begin
      cnt_d = reload_i;
    end else if (live) begin
      if (cnt_q == ONE) begin
        cnt_d = reload_i;
        fire  = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (fire)       flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/rtc_cdtimer.sv
module rtc_cdtimer
  import rtc_cdtimer_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MIN_DIV = 60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_4k_i,
  input  logic             tick_64_i,
  input  logic             tick_1_i,
  input  logic             src_we_i,
  input  logic [1:0]       src_wdata_i,
  input  logic             reload_we_i,
  input  logic [CNT_W-1:0] reload_wdata_i,
  input  logic             ctrl_we_i,
  input  logic             en_wdata_i,
  input  logic             ie_wdata_i,
  input  logic             flag_we_i,
  input  logic             flag_wdata_i,
  output logic             flag_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int MW = $clog2(MIN_DIV);

  tsrc_e            src_q;
  logic             en_q, ie_q;
  logic [CNT_W-1:0] reload_q;
  logic             tick_min, sel_tick;
  logic [MW-1:0]    min_cnt;
  logic             flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= SRC_MIN;
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      reload_q <= '0;
    end else begin
      if (src_we_i)    src_q    <= tsrc_e'(src_wdata_i);
      if (reload_we_i) reload_q <= reload_wdata_i;
      if (ctrl_we_i) begin
        en_q <= en_wdata_i;
        ie_q <= ie_wdata_i;
      end
    end
  end

  rtc_min_div #(.DIV(MIN_DIV)) u_min (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (src_we_i),
    .tick_i (tick_1_i),
    .tick_o (tick_min),
    .cnt_o  (min_cnt)
  );

  rtc_tick_mux #(.NSRC(4)) u_mux (
    .ticks_i ({tick_min, tick_1_i, tick_64_i, tick_4k_i}),
    .sel_i   (src_q),
    .tick_o  (sel_tick)
  );

  rtc_cd_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .tick_i    (sel_tick),
    .reload_i  (reload_q),
    .wr_load_i (reload_we_i),
    .wr_val_i  (reload_wdata_i),
    .en_load_i (ctrl_we_i && en_wdata_i && !en_q),
    .clr_i     (flag_we_i && !flag_wdata_i),
    .cnt_o     (count_o),
    .flag_o    (flag)
  );

  assign flag_o = flag;
  assign irq_o  = flag && ie_q;
endmodule

// File: rtl/rtc_cdtimer_chk.sv
module rtc_cdtimer_chk #(
  parameter int CNT_W   = 8,
  parameter int MIN_DIV = 60,
  localparam int MW     = $clog2(MIN_DIV)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reload_we_i,
  input logic [CNT_W-1:0] reload_wdata_i,
  input logic             ctrl_we_i,
  input logic             flag_we_i,
  input logic             flag_wdata_i,
  input logic             flag_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] count_o,
  input logic             en_q,
  input logic             sel_tick,
  input logic [CNT_W-1:0] reload_q,
  input logic [MW-1:0]    min_cnt
);
  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !(flag_we_i && !flag_wdata_i) |=> flag_o);

  a_r8_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_tick && !reload_we_i && !ctrl_we_i |=> $stable(count_o));

  a_r3_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && sel_tick && count_o > CNT_W'(1) && reload_q != '0 && !reload_we_i && !ctrl_we_i
    |=> count_o == $past(count_o) - CNT_W'(1));

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && sel_tick && count_o == CNT_W'(1) && reload_q != '0 && !reload_we_i && !ctrl_we_i
    |=> flag_o && count_o == $past(reload_q));

  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_we_i && en_q |=> count_o == $past(reload_wdata_i));

  a_r9_zero_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_q == '0 && !flag_o |=> !flag_o);

  a_r2_min_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_cnt < MW'(MIN_DIV));
endmodule

bind rtc_cdtimer rtc_cdtimer_chk #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reload_we_i    (reload_we_i),
  .reload_wdata_i (reload_wdata_i),
  .ctrl_we_i      (ctrl_we_i),
  .flag_we_i      (flag_we_i),
  .flag_wdata_i   (flag_wdata_i),
  .flag_o         (flag_o),
  .irq_o          (irq_o),
  .count_o        (count_o),
  .en_q           (en_q),
  .sel_tick       (sel_tick),
  .reload_q       (reload_q),
  .min_cnt        (min_cnt)
);

// File: tb/tb_rtc_cdtimer.sv
module tb_rtc_cdtimer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic t4k = 1'b0, t64 = 1'b0, t1 = 1'b0;
  logic src_we = 1'b0;
  logic [1:0] src_wd = 2'b00;
  logic rl_we = 1'b0;
  logic [7:0] rl_wd = 8'h00;
  logic ctrl_we = 1'b0, en_wd = 1'b0, ie_wd = 1'b0;
  logic fl_we = 1'b0, fl_wd = 1'b0;
  logic flag, irq;
  logic [7:0] cnt;

  int n_tests = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  bit chk_on = 1'b0;

  always #4 clk = ~clk;

  rtc_cdtimer dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tick_4k_i(t4k), .tick_64_i(t64), .tick_1_i(t1),
    .src_we_i(src_we), .src_wdata_i(src_wd),
    .reload_we_i(rl_we), .reload_wdata_i(rl_wd),
    .ctrl_we_i(ctrl_we), .en_wdata_i(en_wd), .ie_wdata_i(ie_wd),
    .flag_we_i(fl_we), .flag_wdata_i(fl_wd),
    .flag_o(flag), .irq_o(irq), .count_o(cnt)
  );

  // Reference model
  logic [1:0] m_sel;
  logic [7:0] m_rl, m_cnt, nc;
  int m_min;
  logic m_en, m_ie, m_flag, st, setf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 2'b11; m_rl = 0; m_cnt = 0; m_min = 0;
      m_en = 0; m_ie = 0; m_flag = 0;
    end else begin
      case (m_sel)
        2'b00:   st = t4k;
        2'b01:   st = t64;
        2'b10:   st = t1;
        default: st = t1 && (m_min == 59);
      endcase
      nc = m_cnt; setf = 0;
      if (rl_we && m_en) nc = rl_wd;
      else if (ctrl_we && en_wd && !m_en) nc = m_rl;
      else if (m_en && st && m_rl != 0 && m_cnt != 0) begin
        if (m_cnt == 1) begin nc = m_rl; setf = 1; end
        else nc = m_cnt - 1;
      end
      if (setf) m_flag = 1;
      else if (fl_we && !fl_wd) m_flag = 0;
      if (src_we) m_min = 0;
      else if (t1) m_min = (m_min == 59) ? 0 : m_min + 1;
      if (src_we) m_sel = src_wd;
      if (rl_we) m_rl = rl_wd;
      if (ctrl_we) begin m_en = en_wd; m_ie = ie_wd; end
      m_cnt = nc;
    end
  end

  task automatic check(string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  // Tick strobes at compressed rates, plus per-cycle comparison
  always @(negedge clk) begin
    cyc++;
    if (chk_on && rst_n) begin
      check("count", cnt, m_cnt);
      check("flag", flag, m_flag);
      check("irq", irq, m_flag && m_ie);
    end
    t4k <= (cyc % 2) == 0;
    t64 <= (cyc % 5) == 0;
    t1  <= (cyc % 3) == 0;
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic w_src(logic [1:0] v);
    @(negedge clk); src_we <= 1; src_wd <= v;
    @(negedge clk); src_we <= 0;
  endtask

  task automatic w_rl(logic [7:0] v);
    @(negedge clk); rl_we <= 1; rl_wd <= v;
    @(negedge clk); rl_we <= 0;
  endtask

  task automatic w_ctrl(logic e, logic i);
    @(negedge clk); ctrl_we <= 1; en_wd <= e; ie_wd <= i;
    @(negedge clk); ctrl_we <= 0;
  endtask

  task automatic w_flag(logic v);
    @(negedge clk); fl_we <= 1; fl_wd <= v;
    @(negedge clk); fl_we <= 0;
  endtask

  initial begin
    #100000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    cur_req = "R1";
    check("reset count", cnt, 0);
    check("reset flag", flag, 0);
    check("reset irq", irq, 0);
    rst_n = 1;
    chk_on = 1;
    idle(2);
    // R1: default source is 1/60 Hz, so a reload of 1 fires after 60 1 Hz ticks
    cur_req = "R1_R5";
    w_rl(8'd1);
    w_ctrl(1, 1);
    idle(200);
    cur_req = "R7";
    w_flag(1);
    idle(3);
    w_flag(0);
    idle(3);
    // R2 R3 R4 sources 00, 01 and 10
    cur_req = "R2_R4";
    w_src(2'b00); w_rl(8'd3); idle(30);
    cur_req = "R3";
    w_src(2'b01); idle(40);
    w_ctrl(0, 1); idle(20);
    w_ctrl(1, 1); idle(20);
    cur_req = "R2";
    w_src(2'b10); idle(40);
    // R6: reload writes while enabled and while disabled
    cur_req = "R6";
    w_rl(8'd7); idle(5);
    w_ctrl(0, 0); w_rl(8'd2); idle(6);
    w_ctrl(1, 0); idle(20);
    // R8: interrupt gate
    cur_req = "R8";
    w_ctrl(1, 1); idle(5);
    w_ctrl(1, 0); idle(5);
    w_flag(0); idle(2);
    // R7: clear in the same cycle as a timer event
    cur_req = "R7";
    w_src(2'b00); w_rl(8'd1);
    for (int i = 0; i < 6; i++) w_flag(0);
    idle(4);
    // R9: reload of zero
    cur_req = "R9";
    w_flag(0);
    w_rl(8'd0); idle(30);
    w_ctrl(0, 1); w_ctrl(1, 1); idle(30);
    // R2: 1/60 Hz with the divider cleared by a source write partway through
    cur_req = "R2_min";
    w_rl(8'd2);
    w_src(2'b11); idle(100);
    w_src(2'b11); idle(400);
    chk_on = 0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule